// File: doc/BRIEF.md
# Interleaved Dual-Port ADC Capture

This block takes 8-bit samples from two time-interleaved flash converters and turns them into one stream in sampling order. Each converter has two internal quantizers, so it drives two sample ports, A and B, that share one data clock. That clock runs at half the converter's input clock. Port A holds a new sample after the rising edge of the data clock, and port B holds one after the falling edge. The two converters run on alternating input-clock edges, so together they give twice the rate of one converter.

Port A is registered on the rising edge and port B on the falling edge. The port A samples are delayed by one rising edge and the port B samples are moved into the rising-edge domain, so all samples of one data-clock period line up. They are then packed into one output word per period. The earliest sample goes in the least significant byte, and one valid flag covers the whole word. The word is meant to be written into a downstream buffer that runs on the data clock.

Top module: `adc_ilv_capture`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and data_o is all zeros, with no clock edge needed.
- R2: The sample on port A of converter k at a rising edge of clk_i appears in byte k of data_o (bits 8k+7:8k). With two converters, converter 0 is byte 0 and converter 1 is byte 1.
- R3: The sample on port B of converter k at the falling edge that follows that rising edge appears in byte NUM_CONV+k of the same word. With two converters, converter 0 is byte 2 and converter 1 is byte 3.
- R4: Each valid word holds one data-clock period in sampling order, earliest in the least significant byte. For a ramp input, byte i+1 equals byte i plus 1 (modulo 256), and byte 0 of each word equals the top byte of the previous word plus 1.
- R5: Once valid_o is high, it stays high on every following rising edge until reset is asserted.
- R6: After reset is released, valid_o is low after the first and second rising edges and high after the third. The first valid word carries the port A samples taken at the first rising edge and the port B samples taken at the falling edge after it.
- R7: Asserting reset during streaming clears the output and valid flag, and the R6 fill sequence starts again on release.
- R8: Port A values are used only at rising edges and port B values only at falling edges. Any other value on a port between its sampling edges does not reach data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock shared by both converter ports |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_a_i | input | NUM_CONV*SAMPLE_W | Port A samples; converter k in bits 8k+7:8k |
| conv_b_i | input | NUM_CONV*SAMPLE_W | Port B samples; converter k in bits 8k+7:8k |
| data_o | output | 2*NUM_CONV*SAMPLE_W | Packed ordered word, earliest sample in the low byte |
| valid_o | output | 1 | Word on data_o is a complete period |

## Verification
The behavioural converter stub drives a chronological ramp and puts distinct garbage values on each port outside its sampling window. This catches a port captured on the wrong edge, or retimed late, because the wrong edge picks up garbage and a late retime breaks the ramp continuity. With a ramp, a byte-level swap of lanes or converters shows up as an ordering break within a word, while a dropped or repeated period shows up as a gap between words. A start value near 0xF6, run through the 0xFF boundary after a mid-stream reset, checks modulo continuity and the fill latency again after the reset.

// File: rtl/adc_ilv_pkg.sv
package adc_ilv_pkg;
  typedef enum logic [1:0] {
    FILL_EMPTY,
    FILL_ONE,
    FILL_TWO,
    FILL_FULL
  } fill_state_e;
endpackage

// File: rtl/adc_ilv_lane.sv
// One converter: A on rising edge, B on falling edge, both aligned to rising edge.
module adc_ilv_lane #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] a_i,
  input  logic [SAMPLE_W-1:0] b_i,
  output logic [SAMPLE_W-1:0] a_o,
  output logic [SAMPLE_W-1:0] b_o
);
  logic [SAMPLE_W-1:0] a_q, a_r, b_q, b_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      a_r <= '0;
      b_r <= '0;
    end else begin
      a_q <= a_i;
      a_r <= a_q;  // delay A to meet B of the same period
      b_r <= b_q;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) b_q <= '0;
    else         b_q <= b_i;
  end

  assign a_o = a_r;
  assign b_o = b_r;
endmodule

// File: rtl/adc_ilv_fill.sv
module adc_ilv_fill
  import adc_ilv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  output logic valid_o
);
  fill_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FILL_EMPTY;
    else begin
      case (state_q)
        FILL_EMPTY: state_q <= FILL_ONE;
        FILL_ONE:   state_q <= FILL_TWO;
        default:    state_q <= FILL_FULL;
      endcase
    end
  end

  assign valid_o = (state_q == FILL_FULL);

  assert_valid_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  assert_valid_after_history_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(rst_ni, 3));
endmodule

// File: rtl/adc_ilv_merge.sv
// Orders one period: all A lanes by converter, then all B lanes by converter.
module adc_ilv_merge #(
  parameter int SAMPLE_W = 8,
  parameter int NUM_CONV = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CONV*SAMPLE_W-1:0]   a_i,
  input  logic [NUM_CONV*SAMPLE_W-1:0]   b_i,
  output logic [2*NUM_CONV*SAMPLE_W-1:0] data_o
);
  localparam int HALF_W = NUM_CONV * SAMPLE_W;

  logic [2*HALF_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else begin
      word_q[HALF_W-1:0]        <= a_i;
      word_q[2*HALF_W-1:HALF_W] <= b_i;
    end
  end

  assign data_o = word_q;
endmodule

// File: rtl/adc_ilv_capture.sv
module adc_ilv_capture #(
  parameter int SAMPLE_W = 8,
  parameter int NUM_CONV = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CONV*SAMPLE_W-1:0]   conv_a_i,
  input  logic [NUM_CONV*SAMPLE_W-1:0]   conv_b_i,
  output logic [2*NUM_CONV*SAMPLE_W-1:0] data_o,
  output logic                           valid_o
);
  localparam int HALF_W = NUM_CONV * SAMPLE_W;

  logic [HALF_W-1:0] a_al, b_al;

  for (genvar k = 0; k < NUM_CONV; k++) begin : g_lane
    adc_ilv_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .a_i   (conv_a_i[k*SAMPLE_W +: SAMPLE_W]),
      .b_i   (conv_b_i[k*SAMPLE_W +: SAMPLE_W]),
      .a_o   (a_al[k*SAMPLE_W +: SAMPLE_W]),
      .b_o   (b_al[k*SAMPLE_W +: SAMPLE_W])
    );
  end

  adc_ilv_merge #(.SAMPLE_W(SAMPLE_W), .NUM_CONV(NUM_CONV)) u_merge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (a_al),
    .b_i   (b_al),
    .data_o(data_o)
  );

  adc_ilv_fill u_fill (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_o(valid_o)
  );

  // A lanes carry the values seen at the rising edge three edges back
  assert_a_lanes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (data_o[HALF_W-1:0] == $past(conv_a_i, 3)));

  // B lanes carry the values seen at the falling edge two falling edges back
  assert_b_lanes_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    valid_o |-> (data_o[2*HALF_W-1:HALF_W] == $past(conv_b_i, 2)));
endmodule

// File: tb/adc_ilv_capture_test.sv
module adc_ilv_capture_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] conv_a = '0;
  logic [15:0] conv_b = '0;
  logic [31:0] data;
  logic        valid;
  logic [7:0]  base = 8'd0;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  adc_ilv_capture uut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .conv_a_i(conv_a),
    .conv_b_i(conv_b),
    .data_o  (data),
    .valid_o (valid)
  );

  // Converter stub: each port is only meaningful around its own sampling edge
  task automatic stub_run();
    forever begin
      @(negedge clk); #1;
      conv_a = {base + 8'd1, base};
      conv_b = 16'hEEEE;
      @(posedge clk); #1;
      conv_b = {base + 8'd3, base + 8'd2};
      conv_a = 16'h5555;
      base   = base + 8'd4;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic t_reset_state();
    @(negedge clk); #2;
    check(valid == 1'b0, "R1 valid in reset", {31'd0, valid}, 32'd0);
    check(data == 32'd0, "R1 data in reset", data, 32'd0);
  endtask

  task automatic t_latency();
    logic [7:0] b0;
    @(negedge clk); #2;
    rst_ni = 1'b1;
    b0 = base;
    @(posedge clk); #2;
    check(valid == 1'b0, "R6 valid after edge 1", {31'd0, valid}, 32'd0);
    @(posedge clk); #2;
    check(valid == 1'b0, "R6 valid after edge 2", {31'd0, valid}, 32'd0);
    @(posedge clk); #2;
    check(valid == 1'b1, "R6 valid after edge 3", {31'd0, valid}, 32'd1);
    check(data[15:0] == {b0 + 8'd1, b0}, "R2,R8 first word A lanes",
          {16'd0, data[15:0]}, {16'd0, b0 + 8'd1, b0});
    check(data[31:16] == {b0 + 8'd3, b0 + 8'd2}, "R3,R8 first word B lanes",
          {16'd0, data[31:16]}, {16'd0, b0 + 8'd3, b0 + 8'd2});
  endtask

  task automatic t_ramp(input int n);
    logic [7:0] prev_top;
    prev_top = data[31:24];
    for (int p = 0; p < n; p++) begin
      @(posedge clk); #2;
      check(valid == 1'b1, "R5 valid held", {31'd0, valid}, 32'd1);
      check(data[7:0] == prev_top + 8'd1, "R4 continuity across words",
            {24'd0, data[7:0]}, {24'd0, prev_top + 8'd1});
      check(data[15:8] == data[7:0] + 8'd1, "R2,R8 converter order A",
            {24'd0, data[15:8]}, {24'd0, data[7:0] + 8'd1});
      check(data[23:16] == data[15:8] + 8'd1, "R3,R8 A to B order",
            {24'd0, data[23:16]}, {24'd0, data[15:8] + 8'd1});
      check(data[31:24] == data[23:16] + 8'd1, "R3,R4 converter order B",
            {24'd0, data[31:24]}, {24'd0, data[23:16] + 8'd1});
      prev_top = data[31:24];
    end
  endtask

  task automatic t_midreset();
    @(negedge clk); #2;
    rst_ni = 1'b0;
    #0.5;
    check(valid == 1'b0, "R1,R7 valid cleared async", {31'd0, valid}, 32'd0);
    check(data == 32'd0, "R1,R7 data cleared async", data, 32'd0);
    @(posedge clk); #2;
    check(valid == 1'b0, "R7 valid held low in reset", {31'd0, valid}, 32'd0);
    base = 8'hF6;
    t_latency();
  endtask

  initial begin
    fork
      stub_run();
    join_none
    repeat (3) @(posedge clk);
    t_reset_state();
    t_latency();
    t_ramp(40);
    t_midreset();
    t_ramp(12);
    summary();
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end
endmodule